// File: doc/BRIEF.md
# Full-Bridge Converter Real-Time Emulator

This block is a fixed-point, cycle-by-cycle model of a full-bridge DC-DC converter that drives an LC output filter and a resistive load. It is meant for hardware-in-the-loop rigs: a real controller drives the four gate inputs, and the block answers with the inductor current, the capacitor voltage and the output voltage. The output voltage includes the drop across the capacitor ESR. Every enabled clock edge advances one explicit forward-Euler step. The block therefore models a time step equal to the clock period, and the precomputed constants dt/L and dt/C supplied at the ports must match that period.

The losses are runtime inputs: the switch on-resistance, the inductor winding resistance, the capacitor ESR and the freewheeling diode forward voltage. The load is given as a conductance. When neither diagonal switch pair is on, the bridge voltage follows the sign of the inductor current through the diodes. The current is stopped at zero instead of reversing, which reproduces discontinuous conduction. The gates are sampled on every step, so any modulation pattern can be used. The update loop has no pipeline stage: each new state is computed only from the state of the step immediately before.

Top module: `fb_converter_emu`

## Requirements
- R1: A clock edge with `rst` high clears the inductor current, the capacitor voltage and the internal ESR-drop register, so that `i_ind`, `v_cap` and `v_out` all read 0 after that edge.
- R2: An edge with `rst` low and `step_en` low leaves all three outputs unchanged, whatever the gates and the other inputs do.
- R3: When `gate[0]` and `gate[3]` are both high, the bridge voltage is `vin - 2*floor(r_sw*i/2^19)`. This case wins over R4, including when all four gates are high.
- R4: When `gate[1]` and `gate[2]` are both high and R3 does not apply, the bridge voltage is `-vin + 2*floor(r_sw*i/2^19)`.
- R5: When neither pair is fully on, the bridge voltage is `-(vin + 2*vd)` for a positive current and `vin + 2*vd` for a negative current. For a current of exactly zero the bridge voltage is 0 and the inductor current stays 0.
- R6: When neither pair is fully on, a positive current never becomes negative and a negative current never becomes positive: a step that would cross zero leaves the current at exactly 0.
- R7: The number formats and the inductor step are as follows. The current is 40-bit signed with 33 fraction bits. Voltages are 40-bit signed with 30 fraction bits. Resistances are 18-bit signed with 16 fraction bits. `k_ind` is 24-bit signed with 32 fraction bits. The inductor voltage is `vL = sat(bridge - floor(r_ind*i/2^19) - v_cap)`, and the next current is `sat(i + floor(vL*k_ind/2^29))`. All floors are arithmetic right shifts.
- R8: The capacitor step is computed with `g_load` as 18-bit signed with 20 fraction bits and `k_cap` as 24-bit signed with 32 fraction bits. The steps are: `v_out = sat(v_cap + e)`, then `ic = sat(i - floor(g_load*v_out/2^17))`, then the next `v_cap = sat(v_cap + floor(ic*k_cap/2^35))`, and the next `e = sat(floor(r_esr*ic/2^19))`.
- R9: Each enabled edge advances exactly one step, and every state register is updated from the values held before that edge. The new outputs are visible right after the edge. For example, the first step from a zero state with a forward pair gives a current of `floor(vin*k_ind/2^29)` and leaves `v_cap` at 0.
- R10: The bridge voltage, `vL`, the next current, `v_out`, `ic`, the next `v_cap` and the ESR term saturate to the range [-2^39, 2^39-1] instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; one enabled edge is one integration step |
| rst | input | 1 | Synchronous active-high reset of all state |
| step_en | input | 1 | Advances the model on this edge when high |
| gate | input | 4 | Switch gates; bits 0 and 3 are the forward pair, bits 1 and 2 the reverse pair |
| vin | input | 40 | DC input voltage, signed Q9.30 |
| vd | input | 40 | Diode forward voltage, signed Q9.30 |
| r_sw | input | 18 | Switch on-resistance, signed, 16 fraction bits |
| r_ind | input | 18 | Inductor winding resistance, signed, 16 fraction bits |
| r_esr | input | 18 | Capacitor ESR, signed, 16 fraction bits |
| g_load | input | 18 | Load conductance, signed, 20 fraction bits |
| k_ind | input | 24 | dt/L, signed, 32 fraction bits |
| k_cap | input | 24 | dt/C, signed, 32 fraction bits |
| i_ind | output | 40 | Inductor current, signed Q6.33 |
| v_cap | output | 40 | Capacitor voltage, signed Q9.30 |
| v_out | output | 40 | Output voltage including the ESR drop, signed Q9.30 |

## Verification
The hardest case to reach is the zero crossing with only the diodes conducting. To get there, a diagonal pair first builds up a current of known sign. Then all gates are released, and the diode voltage is raised so that the current collapses within a few steps. The bench checks that the current lands exactly on zero and stays there. The rails are reached by setting dt/C to zero, which freezes the capacitor, and setting dt/L to its largest code, so that the current ramps into both limits within a few hundred steps. A bench-side reference model, written from the stated formats, predicts every step, and the scoreboard compares the outputs after each edge.

// File: rtl/fb_emu_pkg.sv
package fb_emu_pkg;

    // Number formats (all signed, sign bit included in the width)
    localparam int ST_W    = 40;   // state and voltage width
    localparam int IL_FRAC = 33;   // inductor current fraction bits
    localparam int VC_FRAC = 30;   // voltage fraction bits
    localparam int R_W     = 18;   // resistance width
    localparam int R_FRAC  = 16;
    localparam int G_W     = 18;   // load conductance width
    localparam int G_FRAC  = 20;
    localparam int K_W     = 24;   // dt/L and dt/C width
    localparam int K_FRAC  = 32;

    localparam int WIDE_W  = 2 * ST_W;

    // Realignment shifts back to the destination format
    localparam int SH_DROP = R_FRAC + IL_FRAC - VC_FRAC;
    localparam int SH_DIL  = VC_FRAC + K_FRAC - IL_FRAC;
    localparam int SH_LOAD = G_FRAC + VC_FRAC - IL_FRAC;
    localparam int SH_DVC  = IL_FRAC + K_FRAC - VC_FRAC;

    typedef logic signed [ST_W-1:0]   st_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic signed [R_W-1:0]    res_t;
    typedef logic signed [G_W-1:0]    cond_t;
    typedef logic signed [K_W-1:0]    coef_t;

    localparam st_t   ST_ZERO = '0;
    localparam st_t   ST_MAX  = {1'b0, {(ST_W-1){1'b1}}};
    localparam st_t   ST_MIN  = {1'b1, {(ST_W-1){1'b0}}};
    localparam coef_t K_ZERO  = '0;

    typedef enum logic [2:0] {
        BR_FWD     = 3'd0,   // forward diagonal pair conducting
        BR_REV     = 3'd1,   // reverse diagonal pair conducting
        BR_DIO_POS = 3'd2,   // diodes carry positive current
        BR_DIO_NEG = 3'd3,   // diodes carry negative current
        BR_OPEN    = 3'd4    // no path, zero current
    } br_mode_t;

    typedef struct packed {
        br_mode_t mode;
        st_t      volt;
    } bridge_t;

    function automatic wide_t widen(input st_t v);
        return wide_t'(v);
    endfunction

    function automatic st_t sat_st(input wide_t x);
        if (x > widen(ST_MAX)) return ST_MAX;
        if (x < widen(ST_MIN)) return ST_MIN;
        return x[ST_W-1:0];
    endfunction

endpackage

// File: rtl/fb_emu_bridge.sv
module fb_emu_bridge
    import fb_emu_pkg::*;
(
    input  logic [3:0] gate,
    input  st_t        il,
    input  st_t        vin,
    input  st_t        vd,
    input  res_t       r_sw,
    output bridge_t    br
);

    logic  fwd_on, rev_on;
    wide_t drop2;
    wide_t dio_v;
    wide_t v_raw;

    assign fwd_on = gate[0] & gate[3];
    assign rev_on = gate[1] & gate[2];

    always_comb begin
        drop2 = ((wide_t'(r_sw) * widen(il)) >>> SH_DROP) <<< 1;
        dio_v = widen(vin) + (widen(vd) <<< 1);
        if (fwd_on) begin
            br.mode = BR_FWD;
            v_raw   = widen(vin) - drop2;
        end else if (rev_on) begin
            br.mode = BR_REV;
            v_raw   = drop2 - widen(vin);
        end else if (il > ST_ZERO) begin
            br.mode = BR_DIO_POS;
            v_raw   = -dio_v;
        end else if (il < ST_ZERO) begin
            br.mode = BR_DIO_NEG;
            v_raw   = dio_v;
        end else begin
            br.mode = BR_OPEN;
            v_raw   = '0;
        end
        br.volt = sat_st(v_raw);
    end

endmodule

// File: rtl/fb_emu_inductor.sv
module fb_emu_inductor
    import fb_emu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  bridge_t br,
    input  st_t     vc,
    input  res_t    r_ind,
    input  coef_t   k_ind,
    output st_t     il_q
);

    wide_t wind_drop;
    st_t   v_l;
    wide_t d_il;
    st_t   il_sum;
    st_t   il_next;

    always_comb begin
        wind_drop = (wide_t'(r_ind) * widen(il_q)) >>> SH_DROP;
        v_l       = sat_st(widen(br.volt) - wind_drop - widen(vc));
        d_il      = (widen(v_l) * wide_t'(k_ind)) >>> SH_DIL;
        il_sum    = sat_st(widen(il_q) + d_il);
        il_next   = il_sum;
        case (br.mode)
            BR_OPEN:    il_next = ST_ZERO;
            BR_DIO_POS: if (il_sum < ST_ZERO) il_next = ST_ZERO;
            BR_DIO_NEG: if (il_sum > ST_ZERO) il_next = ST_ZERO;
            default:    il_next = il_sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     il_q <= ST_ZERO;
        else if (en) il_q <= il_next;
    end

    p_reset_il_r1: assert property (@(posedge clk)
        rst |=> (il_q == ST_ZERO))
        else $error("inductor state not cleared by reset");

    p_hold_il_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(il_q))
        else $error("inductor state moved while disabled");

    p_open_stays_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (en && br.mode == BR_OPEN) |=> (il_q == ST_ZERO))
        else $error("current left zero with the bridge open");

    p_no_cross_pos_r6: assert property (@(posedge clk) disable iff (rst)
        (en && br.mode == BR_DIO_POS) |=> (il_q >= ST_ZERO))
        else $error("positive diode current reversed");

    p_no_cross_neg_r6: assert property (@(posedge clk) disable iff (rst)
        (en && br.mode == BR_DIO_NEG) |=> (il_q <= ST_ZERO))
        else $error("negative diode current reversed");

    p_frozen_without_gain_r7: assert property (@(posedge clk) disable iff (rst)
        (en && k_ind == K_ZERO) |=> $stable(il_q))
        else $error("current moved with zero dt/L");

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (en && br.mode == BR_FWD && v_l > ST_ZERO && k_ind > K_ZERO)
            |=> (il_q >= $past(il_q)))
        else $error("current wrapped under a positive increment");

endmodule

// File: rtl/fb_emu_capacitor.sv
module fb_emu_capacitor
    import fb_emu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  st_t   il,
    input  cond_t g_load,
    input  res_t  r_esr,
    input  coef_t k_cap,
    output st_t   vc_q,
    output st_t   vo
);

    st_t   esr_q;
    wide_t load_i;
    st_t   i_c;
    wide_t d_vc;
    st_t   vc_next;
    st_t   esr_next;

    always_comb begin
        vo       = sat_st(widen(vc_q) + widen(esr_q));
        load_i   = (wide_t'(g_load) * widen(vo)) >>> SH_LOAD;
        i_c      = sat_st(widen(il) - load_i);
        d_vc     = (widen(i_c) * wide_t'(k_cap)) >>> SH_DVC;
        vc_next  = sat_st(widen(vc_q) + d_vc);
        esr_next = sat_st((wide_t'(r_esr) * widen(i_c)) >>> SH_DROP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vc_q  <= ST_ZERO;
            esr_q <= ST_ZERO;
        end else if (en) begin
            vc_q  <= vc_next;
            esr_q <= esr_next;
        end
    end

    p_reset_vc_r1: assert property (@(posedge clk)
        rst |=> (vc_q == ST_ZERO && vo == ST_ZERO))
        else $error("capacitor state not cleared by reset");

    p_hold_vc_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(vc_q) && $stable(vo)))
        else $error("capacitor state moved while disabled");

    p_frozen_without_gain_r8: assert property (@(posedge clk) disable iff (rst)
        (en && k_cap == K_ZERO) |=> $stable(vc_q))
        else $error("capacitor voltage moved with zero dt/C");

endmodule

// File: rtl/fb_converter_emu.sv
module fb_converter_emu
    import fb_emu_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step_en,
    input  logic [3:0]               gate,
    input  logic signed [ST_W-1:0]   vin,
    input  logic signed [ST_W-1:0]   vd,
    input  logic signed [R_W-1:0]    r_sw,
    input  logic signed [R_W-1:0]    r_ind,
    input  logic signed [R_W-1:0]    r_esr,
    input  logic signed [G_W-1:0]    g_load,
    input  logic signed [K_W-1:0]    k_ind,
    input  logic signed [K_W-1:0]    k_cap,
    output logic signed [ST_W-1:0]   i_ind,
    output logic signed [ST_W-1:0]   v_cap,
    output logic signed [ST_W-1:0]   v_out
);

    bridge_t br;
    st_t     il_state;
    st_t     vc_state;
    st_t     vo_comb;

    fb_emu_bridge u_bridge (
        .gate (gate),
        .il   (il_state),
        .vin  (vin),
        .vd   (vd),
        .r_sw (r_sw),
        .br   (br)
    );

    fb_emu_inductor u_ind (
        .clk   (clk),
        .rst   (rst),
        .en    (step_en),
        .br    (br),
        .vc    (vc_state),
        .r_ind (r_ind),
        .k_ind (k_ind),
        .il_q  (il_state)
    );

    fb_emu_capacitor u_cap (
        .clk    (clk),
        .rst    (rst),
        .en     (step_en),
        .il     (il_state),
        .g_load (g_load),
        .r_esr  (r_esr),
        .k_cap  (k_cap),
        .vc_q   (vc_state),
        .vo     (vo_comb)
    );

    assign i_ind = il_state;
    assign v_cap = vc_state;
    assign v_out = vo_comb;

endmodule

// File: tb/fb_converter_emu_tb.sv
module fb_converter_emu_tb;

    localparam int CLK_PERIOD = 10;

    typedef logic signed [127:0] w_t;
    typedef logic signed [39:0]  s40_t;

    typedef struct packed {
        int          due;
        logic [39:0] i;
        logic [39:0] vc;
        logic [39:0] vo;
        logic [63:0] tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              step_en = 1'b0;
    logic [3:0]        gate = 4'b0000;
    s40_t              vin = '0;
    s40_t              vd = '0;
    logic signed [17:0] r_sw = '0;
    logic signed [17:0] r_ind = '0;
    logic signed [17:0] r_esr = '0;
    logic signed [17:0] g_load = '0;
    logic signed [23:0] k_ind = '0;
    logic signed [23:0] k_cap = '0;
    s40_t              i_ind, v_cap, v_out;

    s40_t ref_i = '0, ref_vc = '0, ref_e = '0;
    exp_t q[$];
    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    fb_converter_emu u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .gate(gate),
        .vin(vin), .vd(vd), .r_sw(r_sw), .r_ind(r_ind), .r_esr(r_esr),
        .g_load(g_load), .k_ind(k_ind), .k_cap(k_cap),
        .i_ind(i_ind), .v_cap(v_cap), .v_out(v_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic s40_t sat40(input w_t x);
        w_t hi = (w_t'(1) <<< 39) - 1;
        w_t lo = -(w_t'(1) <<< 39);
        if (x > hi) return hi[39:0];
        if (x < lo) return lo[39:0];
        return x[39:0];
    endfunction

    function automatic s40_t volts_milli(input longint m);
        return 40'((m <<< 30) / 1000);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: applies one edge worth of stimulus and predicts its result
    task automatic do_step(input logic r, input logic e, input logic [3:0] g, input logic [63:0] tag);
        w_t   drop, vb, vl_w, ld;
        s40_t vb40, vl, inew, vo_old, ic, vcn, en_e;
        bit   f, rv;
        exp_t it;
        @(negedge clk);
        rst = r; step_en = e; gate = g;
        if (r) begin
            ref_i = '0; ref_vc = '0; ref_e = '0;
        end else if (e) begin
            f  = g[0] & g[3];
            rv = g[1] & g[2];
            drop = (w_t'(r_sw) * w_t'(ref_i)) >>> 19;
            if (f)               vb = w_t'(vin) - 2 * drop;
            else if (rv)         vb = 2 * drop - w_t'(vin);
            else if (ref_i > 0)  vb = -(w_t'(vin) + 2 * w_t'(vd));
            else if (ref_i < 0)  vb = w_t'(vin) + 2 * w_t'(vd);
            else                 vb = '0;
            vb40 = sat40(vb);
            vl_w = w_t'(vb40) - ((w_t'(r_ind) * w_t'(ref_i)) >>> 19) - w_t'(ref_vc);
            vl   = sat40(vl_w);
            inew = sat40(w_t'(ref_i) + ((w_t'(vl) * w_t'(k_ind)) >>> 29));
            if (!f && !rv) begin
                if (ref_i == 0)                    inew = '0;
                else if (ref_i > 0 && inew < 0)    inew = '0;
                else if (ref_i < 0 && inew > 0)    inew = '0;
            end
            vo_old = sat40(w_t'(ref_vc) + w_t'(ref_e));
            ld   = (w_t'(g_load) * w_t'(vo_old)) >>> 17;
            ic   = sat40(w_t'(ref_i) - ld);
            vcn  = sat40(w_t'(ref_vc) + ((w_t'(ic) * w_t'(k_cap)) >>> 35));
            en_e = sat40((w_t'(r_esr) * w_t'(ic)) >>> 19);
            ref_i = inew; ref_vc = vcn; ref_e = en_e;
        end
        it.due = cyc + 1;
        it.i   = ref_i;
        it.vc  = ref_vc;
        it.vo  = sat40(w_t'(ref_vc) + w_t'(ref_e));
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compares outputs one half period after the edge they belong to
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t it;
            string nm;
            it = q.pop_front();
            nm = $sformatf("%0s", it.tag);
            chk(i_ind == $signed(it.i), {nm, " i_ind"}, longint'(i_ind), longint'($signed(it.i)));
            chk(v_cap == $signed(it.vc), {nm, " v_cap"}, longint'(v_cap), longint'($signed(it.vc)));
            chk(v_out == $signed(it.vo), {nm, " v_out"}, longint'(v_out), longint'($signed(it.vo)));
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        vin    = volts_milli(200000);
        vd     = volts_milli(800);
        r_sw   = 18'sd3277;      // 0.05 ohm
        r_ind  = 18'sd6554;      // 0.1 ohm
        r_esr  = 18'sd1311;      // 0.02 ohm
        g_load = 18'sd104858;    // 0.1 S
        k_ind  = 24'sd687195;    // 1.6e-4
        k_cap  = 24'sd6871948;   // 1.6e-3

        // R1: reset
        do_step(1'b1, 1'b0, 4'b0000, "R1");
        do_step(1'b1, 1'b1, 4'b1001, "R1");

        // R2: disabled edges leave the zero state alone
        for (int k = 0; k < 3; k++) do_step(1'b0, 1'b0, 4'b1001, "R2");
        chk(i_ind == 0 && v_cap == 0 && v_out == 0, "R1", longint'(i_ind), 0);

        // R3 / R9: forward pair from zero
        do_step(1'b0, 1'b1, 4'b1001, "R3");
        do_step(1'b0, 1'b1, 4'b1001, "R3");
        chk(i_ind == 40'sd274878000, "R9", longint'(i_ind), 274878000);
        chk(v_cap == 0, "R9", longint'(v_cap), 0);
        for (int k = 0; k < 40; k++) do_step(1'b0, 1'b1, 4'b1001, "R3");

        // R3: all four gates, forward pair wins
        for (int k = 0; k < 5; k++) do_step(1'b0, 1'b1, 4'b1111, "R3");

        // R4: reverse pair drives current negative
        for (int k = 0; k < 70; k++) do_step(1'b0, 1'b1, 4'b0110, "R4");
        chk(i_ind < 0, "R4", longint'(i_ind), -1);

        // R6: negative current through diodes must stop at zero
        for (int k = 0; k < 40; k++) begin
            do_step(1'b0, 1'b1, 4'b0000, "R6");
            chk(i_ind <= 0, "R6", longint'(i_ind), 0);
        end
        // R5: zero current with bridge open stays zero
        for (int k = 0; k < 10; k++) begin
            do_step(1'b0, 1'b1, 4'b0100, "R5");
            chk(i_ind == 0, "R5", longint'(i_ind), 0);
        end

        // R6: positive current collapses with a large diode drop
        for (int k = 0; k < 10; k++) do_step(1'b0, 1'b1, 4'b1001, "R7");
        vd = volts_milli(50000);
        for (int k = 0; k < 20; k++) begin
            do_step(1'b0, 1'b1, 4'b1000, "R6");
            chk(i_ind >= 0, "R6", longint'(i_ind), 0);
        end
        do_step(1'b0, 1'b1, 4'b0000, "R6");
        chk(i_ind == 0, "R6", longint'(i_ind), 0);

        // R2: disabled mid-run with gates toggling
        for (int k = 0; k < 6; k++) do_step(1'b0, 1'b1, 4'b1001, "R8");
        for (int k = 0; k < 6; k++) do_step(1'b0, 1'b0, (k % 2 == 0) ? 4'b0110 : 4'b1001, "R2");

        // R10: saturation at both rails
        vin   = volts_milli(500000);
        r_ind = '0;
        g_load = '0;
        k_cap = '0;
        k_ind = 24'sh7FFFFF;
        for (int k = 0; k < 200; k++) do_step(1'b0, 1'b1, 4'b1001, "R10");
        do_step(1'b0, 1'b0, 4'b1001, "R10");
        chk(i_ind == 40'sh7F_FFFF_FFFF, "R10", longint'(i_ind), 64'sh7F_FFFF_FFFF);
        for (int k = 0; k < 400; k++) do_step(1'b0, 1'b1, 4'b0110, "R10");
        do_step(1'b0, 1'b0, 4'b0110, "R10");
        chk(i_ind == -(40'sh80_0000_0000), "R10", longint'(i_ind), -64'sh80_0000_0000);

        // R1: reset from a non-zero state
        do_step(1'b1, 1'b1, 4'b1001, "R1");
        do_step(1'b0, 1'b0, 4'b0000, "R1");
        chk(i_ind == 0 && v_cap == 0 && v_out == 0, "R1", longint'(v_cap), 0);

        @(negedge clk);
        @(negedge clk);
        chk(q.size() == 0, "R9", longint'(q.size()), 0);
        done = 1'b1;
        finish_run();
    end

endmodule